// File: doc/BRIEF.md
# Serial ADC Power-Mode Interface Logic

This block is the digital side of a three-wire serial sampling converter, seen from the converter. The host drives an active-low chip select and a serial clock. The block captures a parallel sample word at the start of each frame and shifts out a 16-bit word on a data line that has an output enable, so that it can sit on a shared bus. Both host inputs are resynchronised into the block clock, and edges are found there. The outputs therefore lag the pins by a few block-clock cycles, and each serial clock half-period must last at least four block-clock cycles.

The power state is set only by where the host raises chip select within a frame, counted in serial clock falling edges. Raising it early, inside a middle window, puts the converter to sleep. A sleeping converter wakes only when a whole dummy frame runs past the upper edge of that window. Very short chip-select pulses change nothing. A status flag marks whether the word being sent can be trusted. A second flag models whether the track-and-hold is tracking or holding.

The data path has no valid/ready handshake, and no back-pressure is possible. The host's serial clock paces every bit. The sample input is taken once at each frame start, whatever its state. A bit is never held back, and the host must take each bit in the half-period after the falling edge that presents it.

Top module: `sadc_pm_if`

## Requirements
- R1: A falling edge on chip select starts a frame. The data line is enabled, and the word sent is four zero bits followed by the 12-bit sample captured at that edge, MSB first. Word bit 15 is presented before the first serial clock fall, and word bit 15-k is presented after the k-th fall.
- R2: The output enable drops after the 16th serial clock fall of a frame, and also whenever chip select is high. `sdata_o` reads 0 while it is not enabled.
- R3: `data_valid_o` is 1 while a frame that began in Normal mode is being sent. It is 0 whenever the line is not enabled.
- R4: In Normal mode (mode code 2'b00), raising chip select after at least 2 and fewer than 10 serial clock falls ends the transfer and enters Power-Down (mode code 2'b01).
- R5: In Normal mode, raising chip select after 0 or 1 falls, or after 10 or more falls, leaves the mode at Normal.
- R6: In Power-Down, a chip-select fall enters Powering-Up (mode code 2'b10). Raising chip select there before the 10th fall returns the block to Power-Down, so a burst of eight clocks does not wake it.
- R7: A Powering-Up frame that runs past the 10th fall ends in Normal mode, at the 16th fall or at the chip-select rise, whichever comes first. The wake frame is sent with `data_valid_o` at 0, and the next frame is sent as valid with the correct sample.
- R8: `track_o` is 0 in Power-Down. It stays 0 after the chip-select fall of a wake frame until the first serial clock edge, and is 1 from that edge on. It is 1 in Normal mode.
- R9: The falling-edge count saturates at 16. Extra serial clock falls after the 16th neither re-enable the data line nor change the mode.
- R10: Parameter `PWRON_DOWN` selects the mode after reset. With 0 (the default) the block resets to Normal with `track_o` at 1. With 1 it resets to Power-Down with `track_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low chip select from the host |
| sclk_i | input | 1 | Serial clock from the host, idles high |
| sample_i | input | RESULT_W | Sample word, captured at each frame start |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| data_valid_o | output | 1 | Word being sent is a valid conversion |
| mode_o | output | 2 | Power mode: 00 Normal, 01 Power-Down, 10 Powering-Up |
| track_o | output | 1 | Track-and-hold is tracking (1) or holding (0) |

## Verification
The hardest state to reach is a wake frame that has passed the first serial clock edge but not yet the tenth fall. Here the track flag has already risen, but the mode must still fall back to Power-Down if chip select rises. The bench reaches it by first aborting a Normal frame inside the window, then running an eight-clock frame from Power-Down. It checks the track flag just before and just after the first edge, and the mode after the rise. The window edges are probed with frames of exactly 1, 2, 9 and 10 falls.

// File: rtl/sadc_pm_pkg.sv
package sadc_pm_pkg;
  typedef enum logic [1:0] {
    PM_NORMAL = 2'b00,
    PM_DOWN   = 2'b01,
    PM_WAKE   = 2'b10
  } pm_mode_e;
endpackage

// File: rtl/sadc_edge_det.sv
module sadc_edge_det #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= IDLE;
        else        chain[0] <= async_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= IDLE;
        else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= IDLE;
    else        prev <= chain[STAGES-1];

  assign level_o = chain[STAGES-1];
  assign rise_o  = level_o & ~prev;
  assign fall_o  = ~level_o & prev;
endmodule

// File: rtl/sadc_fall_counter.sv
module sadc_fall_counter #(
  parameter int FRAME_BITS = 16,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(FRAME_BITS);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     cnt_o <= '0;
    else if (start_i)               cnt_o <= '0;
    else if (step_i && cnt_o < TOP) cnt_o <= cnt_o + 1'b1;

  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= TOP);
endmodule

// File: rtl/sadc_frame_tx.sv
module sadc_frame_tx #(
  parameter int FRAME_BITS = 16,
  parameter int RESULT_W   = 12,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                cs_low_i,
  input  logic                sclk_fall_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic                frame_ok_i,
  input  logic [RESULT_W-1:0] sample_i,
  output logic                sdata_o,
  output logic                oe_o,
  output logic                valid_o
);
  localparam int PAD_W = FRAME_BITS - RESULT_W;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic                  ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      oe_o  <= 1'b0;
      ok_q  <= 1'b0;
    end else if (start_i) begin
      shreg <= {{PAD_W{1'b0}}, sample_i};
      oe_o  <= 1'b1;
      ok_q  <= frame_ok_i;
    end else if (stop_i) begin
      oe_o  <= 1'b0;
    end else if (sclk_fall_i && cs_low_i && oe_o) begin
      shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
      if (cnt_i == LAST) oe_o <= 1'b0;
    end
  end

  assign sdata_o = oe_o & shreg[FRAME_BITS-1];
  assign valid_o = oe_o & ok_q;

  // R2
  oe_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_low_i && !stop_i) |-> !oe_o);
  // R1
  oe_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> $past(start_i));
  // R3
  valid_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> oe_o);
endmodule

// File: rtl/sadc_pm_fsm.sv
module sadc_pm_fsm
  import sadc_pm_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int PD_LO      = 2,
  parameter int PD_HI      = 10,
  parameter bit PWRON_DOWN = 1'b0,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  logic             cs_low_i,
  input  logic             sclk_fall_i,
  input  logic             sclk_rise_i,
  input  logic [CNT_W-1:0] cnt_i,
  output pm_mode_e         mode_o,
  output logic             track_o
);
  localparam logic [CNT_W-1:0] LO_C   = CNT_W'(PD_LO);
  localparam logic [CNT_W-1:0] HI_C   = CNT_W'(PD_HI);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(FRAME_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o  <= PWRON_DOWN ? PM_DOWN : PM_NORMAL;
      track_o <= !PWRON_DOWN;
    end else if (cs_fall_i) begin
      if (mode_o == PM_DOWN) mode_o <= PM_WAKE;
    end else if (cs_rise_i) begin
      case (mode_o)
        PM_NORMAL:
          if (cnt_i >= LO_C && cnt_i < HI_C) begin
            mode_o  <= PM_DOWN;
            track_o <= 1'b0;
          end
        PM_WAKE:
          if (cnt_i < HI_C) begin
            mode_o  <= PM_DOWN;
            track_o <= 1'b0;
          end else begin
            mode_o  <= PM_NORMAL;
            track_o <= 1'b1;
          end
        default: ;
      endcase
    end else if (cs_low_i && mode_o == PM_WAKE) begin
      if (sclk_fall_i || sclk_rise_i) track_o <= 1'b1;
      if (sclk_fall_i && cnt_i == LAST_C) mode_o <= PM_NORMAL;
    end
  end

  // R6
  no_direct_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_DOWN) |=> (mode_o != PM_NORMAL));
  // R8
  track_rise_in_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_o) |-> (mode_o == PM_WAKE || mode_o == PM_NORMAL));
  // R5
  glitch_keep_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_NORMAL && cs_rise_i && cnt_i < LO_C) |=> (mode_o == PM_NORMAL));
  // R8
  down_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == PM_DOWN) |-> !track_o);
endmodule

// File: rtl/sadc_pm_if.sv
module sadc_pm_if
  import sadc_pm_pkg::*;
#(
  parameter int FRAME_BITS  = 16,
  parameter int RESULT_W    = 12,
  parameter int PD_LO       = 2,
  parameter int PD_HI       = 10,
  parameter int SYNC_STAGES = 2,
  parameter bit PWRON_DOWN  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n_i,
  input  logic                sclk_i,
  input  logic [RESULT_W-1:0] sample_i,
  output logic                sdata_o,
  output logic                sdata_oe_o,
  output logic                data_valid_o,
  output logic [1:0]          mode_o,
  output logic                track_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic             cs_lvl, cs_rise, cs_fall;
  logic             sclk_lvl, sclk_rise, sclk_fall;
  logic [CNT_W-1:0] cnt;
  pm_mode_e         mode;
  logic             cs_low;

  sadc_edge_det #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) cs_det_i (
    .clk(clk), .rst_n(rst_n), .async_i(cs_n_i),
    .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));

  sadc_edge_det #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) sclk_det_i (
    .clk(clk), .rst_n(rst_n), .async_i(sclk_i),
    .level_o(sclk_lvl), .rise_o(sclk_rise), .fall_o(sclk_fall));

  assign cs_low = ~cs_lvl;

  sadc_fall_counter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .start_i(cs_fall),
    .step_i(sclk_fall & cs_low), .cnt_o(cnt));

  sadc_pm_fsm #(.FRAME_BITS(FRAME_BITS), .PD_LO(PD_LO), .PD_HI(PD_HI),
                .PWRON_DOWN(PWRON_DOWN), .CNT_W(CNT_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .cs_low_i(cs_low), .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise),
    .cnt_i(cnt), .mode_o(mode), .track_o(track_o));

  sadc_frame_tx #(.FRAME_BITS(FRAME_BITS), .RESULT_W(RESULT_W), .CNT_W(CNT_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .start_i(cs_fall), .stop_i(cs_rise),
    .cs_low_i(cs_low), .sclk_fall_i(sclk_fall), .cnt_i(cnt),
    .frame_ok_i(mode == PM_NORMAL), .sample_i(sample_i),
    .sdata_o(sdata_o), .oe_o(sdata_oe_o), .valid_o(data_valid_o));

  assign mode_o = mode;

  logic unused_lvl;
  assign unused_lvl = sclk_lvl;
endmodule

// File: tb/sadc_pm_if_tb.sv
module sadc_pm_if_tb_top;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic [11:0] sample = '0;
  logic        sdata, oe, vld, track;
  logic [1:0]  mode;
  logic        sdata2, oe2, vld2, track2;
  logic [1:0]  mode2;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sadc_pm_if dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sample_i(sample),
    .sdata_o(sdata), .sdata_oe_o(oe), .data_valid_o(vld), .mode_o(mode),
    .track_o(track));

  sadc_pm_if #(.PWRON_DOWN(1'b1)) dut_pd_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sample_i(sample),
    .sdata_o(sdata2), .sdata_oe_o(oe2), .data_valid_o(vld2), .mode_o(mode2),
    .track_o(track2));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  // Runs one frame of nfall serial clock falls and records what the line did.
  task automatic frame(input int nfall, input logic [11:0] smp,
                       output logic [15:0] word, output logic v0,
                       output logic [1:0] mode_mid, output logic tr0,
                       output logic tr1, output logic oe_late);
    word = '0; tr1 = 1'b0; oe_late = 1'b0;
    sample = smp;
    wait_h();
    cs_n = 1'b0;
    wait_h();
    mode_mid = mode; tr0 = track; v0 = vld;
    if (oe) word[15] = sdata;
    for (int k = 1; k <= nfall; k++) begin
      sclk = 1'b0;
      wait_h();
      if (k == 1) tr1 = track;
      if (k < 16 && oe) word[15-k] = sdata;
      if (k >= 16 && oe) oe_late = 1'b1;
      sclk = 1'b1;
      wait_h();
    end
    cs_n = 1'b1;
    wait_h();
  endtask

  task automatic t_reset();
    chk("R10 reset mode normal", mode, 2'b00);
    chk("R10 reset track", track, 1'b1);
    chk("R2 reset oe", oe, 1'b0);
    chk("R3 reset valid", vld, 1'b0);
    chk("R10 pd-start mode", mode2, 2'b01);
    chk("R10 pd-start track", track2, 1'b0);
  endtask

  task automatic t_normal(input logic [11:0] smp);
    logic [15:0] w; logic v0, t0, t1, ol; logic [1:0] mm;
    frame(16, smp, w, v0, mm, t0, t1, ol);
    chk("R1 word", w, {4'b0, smp});
    chk("R3 valid", v0, 1'b1);
    chk("R2 oe after frame", oe, 1'b0);
    chk("R2 sdata idle", sdata, 1'b0);
    chk("R5 full frame mode", mode, 2'b00);
    chk("R8 normal track", t1, 1'b1);
  endtask

  task automatic t_glitch(input int n);
    logic [15:0] w; logic v0, t0, t1, ol; logic [1:0] mm;
    frame(n, 12'h123, w, v0, mm, t0, t1, ol);
    chk($sformatf("R5 glitch %0d mode", n), mode, 2'b00);
    chk("R2 oe after abort", oe, 1'b0);
  endtask

  task automatic t_pd(input int n, input logic [1:0] exp_mode);
    logic [15:0] w; logic v0, t0, t1, ol; logic [1:0] mm;
    frame(n, 12'h0F0, w, v0, mm, t0, t1, ol);
    chk($sformatf("R4 cs rise at %0d mode", n), mode, exp_mode);
    chk("R2 oe after rise", oe, 1'b0);
    chk("R8 track after", track, exp_mode == 2'b01 ? 1'b0 : 1'b1);
  endtask

  task automatic t_burst8();
    logic [15:0] w; logic v0, t0, t1, ol; logic [1:0] mm;
    frame(8, 12'h555, w, v0, mm, t0, t1, ol);
    chk("R6 wake mode in frame", mm, 2'b10);
    chk("R8 hold before first edge", t0, 1'b0);
    chk("R8 track after first edge", t1, 1'b1);
    chk("R6 burst back to down", mode, 2'b01);
    chk("R8 track after burst", track, 1'b0);
  endtask

  task automatic t_wake();
    logic [15:0] w; logic v0, t0, t1, ol; logic [1:0] mm;
    frame(16, 12'h3C3, w, v0, mm, t0, t1, ol);
    chk("R6 wake mode", mm, 2'b10);
    chk("R7 wake frame invalid", v0, 1'b0);
    chk("R8 wake hold then track", {t0, t1}, 2'b01);
    chk("R7 normal after wake", mode, 2'b00);
    frame(16, 12'hB7E, w, v0, mm, t0, t1, ol);
    chk("R7 next frame valid", v0, 1'b1);
    chk("R7 next frame word", w, 16'h0B7E);
  endtask

  task automatic t_sat();
    logic [15:0] w; logic v0, t0, t1, ol; logic [1:0] mm;
    frame(21, 12'hFFF, w, v0, mm, t0, t1, ol);
    chk("R9 word with extra clocks", w, 16'h0FFF);
    chk("R9 no drive after 16", ol, 1'b0);
    chk("R9 mode unchanged", mode, 2'b00);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_h();
    t_reset();
    t_normal(12'hA5C);
    t_normal(12'h801);
    t_glitch(0);
    t_glitch(1);
    t_pd(10, 2'b00);
    t_pd(9, 2'b01);
    t_burst8();
    t_wake();
    t_pd(2, 2'b01);
    t_wake();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule